// File: doc/BRIEF.md
# Transport Stream PID Filter

This block sits between a byte-wide MPEG transport stream source and a capture stage. It tracks 188-byte packets, marked by a start strobe on the first byte. For each packet it reads the 13-bit packet identifier (PID) from the header and decides whether the packet goes downstream. Forwarded packets come out packed into 32-bit words, with a valid strobe and an end-of-packet marker on the last word. Dropped packets produce nothing at the output.

Software sets the filter up through a small 32-bit register bank with eight PID match slots. Each slot has its own enable bit. The first slot's register also holds three global controls:
- a pass-all control, which forwards every well-formed packet;
- a filter-off control, which suppresses all output;
- a byte-order control, which chooses how bytes are packed into output words.

The forward decision is made when the third header byte arrives. The first three bytes are already held for word packing, so no extra packet buffer is needed.

Top module: `ts_pid_filter`

## Requirements
- R1: After reset every slot register reads 0x00001FFF (PID field all ones, enable clear), all global controls are clear, and no output beat is produced.
- R2: Slot n is at byte address 4*n. Bits 12:0 hold the slot PID and bit 15 holds the slot enable. In slot 0 only, bit 13 is filter-off, bit 14 is byte order and bit 16 is pass-all. Every other bit reads back as 0, and so do bits 13, 14 and 16 of slots 1 to 7.
- R3: The packet PID is the low 5 bits of header byte 1 (upper PID bits) followed by header byte 2 (lower PID bits). The top 3 bits of byte 1 have no effect on the decision.
- R4: A packet is forwarded only if its first byte is 0x47, filter-off is clear, and either pass-all is set or some enabled slot holds an equal PID. Filter-off overrides pass-all.
- R5: A slot whose enable bit is clear never causes a match, even when its PID field equals the packet PID.
- R6: A forwarded packet produces exactly 47 output beats. A beat appears in the cycle after the clock edge that accepts byte 4k+3 of the packet. out_eop_o is high on the 47th beat and on no other beat.
- R7: With byte order 0, the earliest byte of each group of four sits in out_data_o[31:24]. With byte order 1, it sits in out_data_o[7:0].
- R8: A dropped packet, including one whose first byte is not 0x47, produces no output beat.
- R9: A start strobe in the middle of a packet abandons that packet and starts a new one at that byte. Bytes that arrive without a start strobe while no packet is open are ignored. Cycles with ts_valid_i low neither advance nor disturb the packet.
- R10: The forward decision and the byte order come from the register contents in the cycle the third packet byte is accepted. A register write in that same cycle, or any later write, does not affect the current packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| ts_valid_i | input | 1 | Stream byte valid |
| ts_sop_i | input | 1 | Marks the first byte of a packet |
| ts_data_i | input | 8 | Stream byte |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 32 | Packed output word |
| out_eop_o | output | 1 | Last word of a forwarded packet |

## Verification
A register write can land in the same cycle as the third byte of a packet, which is the byte that triggers the forward decision. The bench provokes this by pulsing a slot enable exactly on that byte. It expects the packet to be dropped under the old settings and the next packet to be forwarded. It also rewrites filter-off and byte order in the middle of a forwarded packet and expects that packet to finish whole, in its original order. The packet after it must be dropped.

// File: rtl/ts_filt_pkg.sv
package ts_filt_pkg;
  localparam int PID_W     = 13;
  localparam int BYTE_W    = 8;
  localparam int WB        = 4;
  localparam int LANE_W    = $clog2(WB);
  localparam logic [7:0] SYNC_BYTE = 8'h47;
  localparam int EN_BIT    = 15;
  localparam int OFF_BIT   = 13;
  localparam int ORD_BIT   = 14;
  localparam int PASS_BIT  = 16;

  typedef struct packed {
    logic pass_all;
    logic filt_off;
    logic le_order;
  } mode_t;
endpackage

// File: rtl/ts_filt_regs.sv
module ts_filt_regs import ts_filt_pkg::*; #(
  parameter int NSLOT = 8,
  localparam int SEL_W = $clog2(NSLOT),
  localparam int ADDR_W = SEL_W + 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  output logic [NSLOT-1:0][PID_W-1:0] pid_o,
  output logic [NSLOT-1:0]            en_o,
  output mode_t                       mode_o
);
  logic [SEL_W-1:0] sel;
  mode_t mode_q;
  assign sel = addr_i[ADDR_W-1:2];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [PID_W-1:0] pid_r;
    logic             en_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pid_r <= '1;
        en_r  <= 1'b0;
      end else if (wr_i && sel == SEL_W'(g)) begin
        pid_r <= wdata_i[PID_W-1:0];
        en_r  <= wdata_i[EN_BIT];
      end
    end
    assign pid_o[g] = pid_r;
    assign en_o[g]  = en_r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else if (wr_i && sel == '0) begin
      mode_q.pass_all <= wdata_i[PASS_BIT];
      mode_q.filt_off <= wdata_i[OFF_BIT];
      mode_q.le_order <= wdata_i[ORD_BIT];
    end
  end
  assign mode_o = mode_q;

  always_comb begin
    rdata_o = '0;
    rdata_o[PID_W-1:0] = pid_o[sel];
    rdata_o[EN_BIT]    = en_o[sel];
    if (sel == '0) begin
      rdata_o[PASS_BIT] = mode_q.pass_all;
      rdata_o[OFF_BIT]  = mode_q.filt_off;
      rdata_o[ORD_BIT]  = mode_q.le_order;
    end
  end

  // R10: configuration only moves on a write
  a_r10_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) |-> ($stable(pid_o) && $stable(en_o) && $stable(mode_q)));
endmodule

// File: rtl/ts_pid_match.sv
module ts_pid_match import ts_filt_pkg::*; #(
  parameter int NSLOT = 8
) (
  input  logic [PID_W-1:0]            pid_i,
  input  logic [NSLOT-1:0][PID_W-1:0] slot_pid_i,
  input  logic [NSLOT-1:0]            slot_en_i,
  output logic                        hit_o
);
  logic [NSLOT-1:0] hit_vec;
  for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
    assign hit_vec[g] = slot_en_i[g] && (slot_pid_i[g] == pid_i);
  end
  assign hit_o = |hit_vec;
endmodule

// File: rtl/ts_pkt_track.sv
module ts_pkt_track import ts_filt_pkg::*; #(
  parameter int PKT_LEN = 188,
  localparam int IDX_W = $clog2(PKT_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic [7:0]        data_i,
  input  logic              hit_i,
  input  mode_t             mode_i,
  output logic [PID_W-1:0]  pid_o,
  output logic              acc_o,
  output logic [LANE_W-1:0] lane_o,
  output logic              last_o,
  output logic              fwd_o,
  output logic              le_o
);
  logic [IDX_W-1:0] idx_q, cur_idx;
  logic in_pkt_q, sync_ok_q, fwd_q, le_q;
  logic [PID_W-BYTE_W-1:0] hdr_hi_q;

  assign cur_idx = sop_i ? '0 : idx_q;
  assign acc_o   = valid_i && (sop_i || in_pkt_q);
  assign lane_o  = cur_idx[LANE_W-1:0];
  assign last_o  = (cur_idx == IDX_W'(PKT_LEN-1));
  assign pid_o   = {hdr_hi_q, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      in_pkt_q  <= 1'b0;
      sync_ok_q <= 1'b0;
      fwd_q     <= 1'b0;
      le_q      <= 1'b0;
      hdr_hi_q  <= '0;
    end else if (acc_o) begin
      if (last_o) begin
        idx_q    <= '0;
        in_pkt_q <= 1'b0;
      end else begin
        idx_q    <= cur_idx + 1'b1;
        in_pkt_q <= 1'b1;
      end
      if (cur_idx == IDX_W'(0)) begin
        sync_ok_q <= (data_i == SYNC_BYTE);
        fwd_q     <= 1'b0;
      end
      if (cur_idx == IDX_W'(1)) hdr_hi_q <= data_i[PID_W-BYTE_W-1:0];
      if (cur_idx == IDX_W'(2)) begin
        fwd_q <= sync_ok_q && !mode_i.filt_off && (mode_i.pass_all || hit_i);
        le_q  <= mode_i.le_order;
      end
    end
  end

  assign fwd_o = fwd_q;
  assign le_o  = le_q;

  a_r4_fwd_needs_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_q |-> sync_ok_q);
  a_r9_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IDX_W'(PKT_LEN));
  a_r9_idle_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_pkt_q |-> idx_q == '0);
endmodule

// File: rtl/ts_word_pack.sv
module ts_word_pack import ts_filt_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic              last_i,
  input  logic [7:0]        data_i,
  input  logic              fwd_i,
  input  logic              le_i,
  output logic              valid_o,
  output logic [WB*8-1:0]   data_o,
  output logic              eop_o
);
  logic [WB-2:0][7:0] stash_q;
  logic [WB*8-1:0]    word;
  logic               full;

  assign full = (lane_i == LANE_W'(WB-1));

  always_comb begin
    word = '0;
    for (int k = 0; k < WB; k++) begin
      if (le_i) word[8*k +: 8]        = (k == WB-1) ? data_i : stash_q[k];
      else      word[8*(WB-1-k) +: 8] = (k == WB-1) ? data_i : stash_q[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stash_q <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      eop_o   <= 1'b0;
    end else begin
      valid_o <= acc_i && full && fwd_i;
      eop_o   <= acc_i && full && fwd_i && last_i;
      if (acc_i && !full) stash_q[lane_i[LANE_W-1:0]] <= data_i;
      if (acc_i && full)  data_o <= word;
    end
  end

  a_r6_eop_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> valid_o);
  a_r6_beat_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/ts_pid_filter.sv
module ts_pid_filter import ts_filt_pkg::*; #(
  parameter int NSLOT = 8,
  parameter int PKT_LEN = 188,
  localparam int ADDR_W = $clog2(NSLOT) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              ts_valid_i,
  input  logic              ts_sop_i,
  input  logic [7:0]        ts_data_i,
  output logic              out_valid_o,
  output logic [31:0]       out_data_o,
  output logic              out_eop_o
);
  logic [NSLOT-1:0][PID_W-1:0] slot_pid;
  logic [NSLOT-1:0]            slot_en;
  mode_t                       mode;
  logic [PID_W-1:0]            pkt_pid;
  logic                        hit, acc, last, fwd, le;
  logic [LANE_W-1:0]           lane;

  ts_filt_regs #(.NSLOT(NSLOT)) regs_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .pid_o(slot_pid),
    .en_o(slot_en), .mode_o(mode));

  ts_pid_match #(.NSLOT(NSLOT)) match_i (
    .pid_i(pkt_pid), .slot_pid_i(slot_pid), .slot_en_i(slot_en), .hit_o(hit));

  ts_pkt_track #(.PKT_LEN(PKT_LEN)) track_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(ts_valid_i), .sop_i(ts_sop_i),
    .data_i(ts_data_i), .hit_i(hit), .mode_i(mode), .pid_o(pkt_pid),
    .acc_o(acc), .lane_o(lane), .last_o(last), .fwd_o(fwd), .le_o(le));

  ts_word_pack pack_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .acc_i(acc), .lane_i(lane), .last_i(last),
    .data_i(ts_data_i), .fwd_i(fwd), .le_i(le), .valid_o(out_valid_o),
    .data_o(out_data_o), .eop_o(out_eop_o));
endmodule

// File: tb/ts_pid_filter_tb.sv
module ts_pid_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 188;
  localparam int NBEAT = PLEN / 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic ts_valid = 1'b0, ts_sop = 1'b0;
  logic [7:0] ts_data = '0;
  logic out_valid, out_eop;
  logic [31:0] out_data;

  int n_tests = 0, n_fail = 0;
  logic [7:0]  pkt_b [PLEN];
  logic [31:0] mon_w [64];
  logic        mon_e [64];
  int mon_n = 0;

  logic [12:0] sh_pid [8];
  logic        sh_en  [8];
  logic sh_pass = 0, sh_off = 0, sh_ord = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_pid_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .ts_valid_i(ts_valid),
    .ts_sop_i(ts_sop), .ts_data_i(ts_data), .out_valid_o(out_valid),
    .out_data_o(out_data), .out_eop_o(out_eop));

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (mon_n < 64) begin
        mon_w[mon_n] = out_data;
        mon_e[mon_n] = out_eop;
      end
      mon_n++;
    end
  end

  function automatic logic [31:0] slot_word(int i);
    logic [31:0] w = '0;
    w[12:0] = sh_pid[i];
    w[15] = sh_en[i];
    if (i == 0) begin
      w[16] = sh_pass; w[14] = sh_ord; w[13] = sh_off;
    end
    return w;
  endfunction

  function automatic logic model_fwd(logic [12:0] pid, logic [7:0] sync);
    logic hit = 1'b0;
    for (int i = 0; i < 8; i++) if (sh_en[i] && sh_pid[i] == pid) hit = 1'b1;
    return (sync == 8'h47) && !sh_off && (sh_pass || hit);
  endfunction

  task automatic wr_slot(int i);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(i * 4); reg_wdata = slot_word(i);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic check(string req, logic ok, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic send_pkt(logic [12:0] pid, logic [7:0] sync, logic [2:0] top,
                          logic [7:0] seed, int gap, int wr_idx,
                          logic [4:0] waddr, logic [31:0] wd, int stop_at);
    pkt_b[0] = sync;
    pkt_b[1] = {top, pid[12:8]};
    pkt_b[2] = pid[7:0];
    for (int k = 3; k < PLEN; k++) pkt_b[k] = 8'(seed + k * 7);
    mon_n = 0;
    for (int k = 0; k < stop_at; k++) begin
      @(negedge clk);
      ts_valid = 1'b1; ts_sop = (k == 0); ts_data = pkt_b[k];
      reg_wr = (k == wr_idx); reg_addr = waddr; reg_wdata = wd;
      if (gap > 0 && (k % gap) == gap - 1) begin
        @(negedge clk);
        ts_valid = 1'b0; ts_sop = 1'b0; reg_wr = 1'b0; ts_data = 8'h47;
      end
    end
    @(negedge clk);
    ts_valid = 1'b0; ts_sop = 1'b0; reg_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_pkt(string req, logic exp_fwd, logic ord);
    logic ok = 1'b1;
    logic [31:0] ew = '0;
    int bad = -1;
    if (!exp_fwd) begin
      check(req, mon_n == 0, "beats of dropped packet", mon_n, 0);
      return;
    end
    if (mon_n != NBEAT) begin
      check(req, 1'b0, "beat count", mon_n, NBEAT);
      return;
    end
    for (int j = 0; j < NBEAT; j++) begin
      for (int k = 0; k < 4; k++) begin
        if (ord) ew[8*k +: 8] = pkt_b[4*j+k];
        else     ew[8*(3-k) +: 8] = pkt_b[4*j+k];
      end
      if (bad < 0 && (mon_w[j] != ew || mon_e[j] != (j == NBEAT-1))) begin
        bad = j; ok = 1'b0;
        check(req, 1'b0, $sformatf("beat %0d word/eop", j),
              {mon_e[j], mon_w[j]}, {(j == NBEAT-1), ew});
      end
    end
    if (ok) check(req, 1'b1, "packet", 0, 0);
  endtask

  task automatic run_pkt(string req, logic [12:0] pid, logic [7:0] sync,
                         logic [2:0] top, logic [7:0] seed, int gap);
    logic e = model_fwd(pid, sync);
    logic o = sh_ord;
    send_pkt(pid, sync, top, seed, gap, -1, 5'd0, 32'd0, PLEN);
    check_pkt(req, e, o);
  endtask

  task automatic read_chk(string req, int i, logic [31:0] exp);
    @(negedge clk);
    reg_addr = 5'(i * 4);
    #1;
    check(req, reg_rdata == exp, $sformatf("slot %0d readback", i), reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [12:0] plist [4];
    for (int i = 0; i < 8; i++) begin sh_pid[i] = 13'h1FFF; sh_en[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R1", out_valid == 1'b0, "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 8; i++) read_chk("R1", i, 32'h0000_1FFF);
    run_pkt("R1", 13'h1FFF, 8'h47, 3'd0, 8'h11, 0);

    // R2 field placement and unused bits
    @(negedge clk); reg_wr = 1; reg_addr = 5'd12; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk); reg_wr = 1; reg_addr = 5'd0;  reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk); reg_wr = 0;
    read_chk("R2", 3, 32'h0000_9FFF);
    read_chk("R2", 0, 32'h0001_FFFF);
    wr_slot(0); wr_slot(3);
    read_chk("R2", 0, 32'h0000_1FFF);

    // R4 R7 R3 sweep of global modes against a fixed slot set
    sh_pid[1] = 13'h1A5; sh_en[1] = 1; wr_slot(1);
    sh_pid[6] = 13'h000; sh_en[6] = 1; wr_slot(6);
    plist[0] = 13'h1A5; plist[1] = 13'h000; plist[2] = 13'h1FFF; plist[3] = 13'h0A5;
    for (int m = 0; m < 8; m++) begin
      sh_pass = m[0]; sh_ord = m[1]; sh_off = m[2];
      wr_slot(0);
      for (int p = 0; p < 4; p++)
        run_pkt(m[1] ? "R7" : "R4", plist[p], 8'h47, 3'(m + p), 8'(m * 16 + p), (p == 3) ? 5 : 0);
    end
    sh_pass = 0; sh_ord = 0; sh_off = 0; wr_slot(0);
    // R3 upper bits of byte 1 ignored; R8 bad sync dropped
    run_pkt("R3", 13'h1A5, 8'h47, 3'b111, 8'h5A, 0);
    run_pkt("R8", 13'h1A5, 8'h46, 3'b000, 8'h5B, 0);
    sh_pass = 1; wr_slot(0);
    run_pkt("R8", 13'h0777, 8'hB8, 3'b000, 8'h5C, 0);
    sh_pass = 0; sh_en[1] = 0; sh_en[6] = 0; wr_slot(0); wr_slot(1); wr_slot(6);

    // R5 per-slot sweep: match, near miss, disabled
    for (int s = 0; s < 8; s++) begin
      logic [12:0] ps = 13'(13'h037 + s * 13'h2F1);
      sh_pid[s] = ps; sh_en[s] = 1; wr_slot(s);
      run_pkt("R4", ps, 8'h47, 3'd2, 8'(s), 0);
      run_pkt("R4", ps ^ 13'h1000, 8'h47, 3'd0, 8'(s + 1), 0);
      sh_en[s] = 0; wr_slot(s);
      run_pkt("R5", ps, 8'h47, 3'd0, 8'(s + 2), 0);
      sh_pid[s] = 13'h1FFF; wr_slot(s);
    end

    // R6 timing with stalls: gaps every byte still give 47 beats
    sh_pass = 1; wr_slot(0);
    run_pkt("R6", 13'h0100, 8'h47, 3'd0, 8'h33, 1);

    // R9 restart on start strobe mid-packet
    send_pkt(13'h0200, 8'h47, 3'd0, 8'h40, 0, -1, 5'd0, 32'd0, 50);
    check("R9", mon_n == 12, "beats of abandoned packet", mon_n, 12);
    check("R9", mon_e[11] == 1'b0, "eop on abandoned packet", mon_e[11], 0);
    run_pkt("R9", 13'h0201, 8'h47, 3'd0, 8'h41, 0);
    // R9 stray bytes without start strobe
    mon_n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); ts_valid = 1; ts_sop = 0; ts_data = 8'h47;
    end
    @(negedge clk); ts_valid = 0;
    repeat (3) @(negedge clk);
    check("R9", mon_n == 0, "beats from stray bytes", mon_n, 0);
    sh_pass = 0; wr_slot(0);

    // R10 write coinciding with the decision byte
    sh_pid[2] = 13'h0AB; sh_en[2] = 1;
    send_pkt(13'h0AB, 8'h47, 3'd0, 8'h70, 0, 2, 5'd8, slot_word(2), PLEN);
    check_pkt("R10", 1'b0, 1'b0);
    run_pkt("R10", 13'h0AB, 8'h47, 3'd0, 8'h71, 0);
    // R10 mode change mid-payload does not touch current packet
    sh_off = 1; sh_ord = 1;
    send_pkt(13'h0AB, 8'h47, 3'd0, 8'h72, 0, 10, 5'd0, slot_word(0), PLEN);
    check_pkt("R10", 1'b1, 1'b0);
    run_pkt("R10", 13'h0AB, 8'h47, 3'd0, 8'h73, 0);
    sh_off = 0; wr_slot(0);
    run_pkt("R7", 13'h0AB, 8'h47, 3'd0, 8'h74, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule